// File: doc/BRIEF.md
# Nine-bit replay FIFO

This block is a single-clock first-in first-out buffer for nine-bit words. A producer pushes a word by raising the write enable with the data present; a consumer pops one by raising the read enable, and the popped word appears on the registered data output on the following clock. Write and read positions are tracked by two internal pointers, so callers never supply an address. A push and a pop may be requested in the same cycle. All nine bits are stored and returned unchanged, so the top bit can carry parity or a control marker.

Three status outputs report the fill state: empty, full, and more-than-half-full. A pop while empty and a push while full are refused and leave the stored contents, pointers and fill count as they were. A rewind input sends the read position back to the first location written since reset, so that everything written so far can be read out again; the write position is kept. Storage depth is a parameter taking 256, 512 or 1024 words.

Top module: `fifo9_replay`

## Requirements
- R1: All nine bits of a word, including bit 8, are returned exactly as written.
- R2: Words are popped in exactly the order in which they were accepted, including across the wrap of the storage addresses.
- R3: A push and a pop requested in the same cycle, with the buffer neither empty nor full and no rewind, are both accepted and the fill count is unchanged.
- R4: `empty` is 1 exactly when the fill count is 0; a pop request while empty is refused, the fill count stays 0 and `rd_data` keeps its value.
- R5: `full` is 1 exactly when the fill count equals DEPTH; a push request while full is refused and the refused word is never returned by a later pop, while a pop in the same cycle is still accepted.
- R6: `half_full` is 1 exactly when the fill count is strictly greater than DEPTH/2; at exactly DEPTH/2 it is 0.
- R7: A cycle with `rewind` high sets the read position to the first location and the fill count to the number of words written since reset (assuming fewer than DEPTH pops have wrapped the buffer); push and pop requests in that cycle are ignored.
- R8: While `rst` is high at a clock edge the block becomes empty: `empty`=1, `full`=0, `half_full`=0, `rd_data`=0 and all pointers at the first location.
- R9: `rd_data` changes only on the clock edge that accepts a pop, and then carries the popped word; in every other cycle it holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; everything samples on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Push request |
| wr_data | input | 9 | Word to push |
| rd_en | input | 1 | Pop request |
| rd_data | output | 9 | Registered popped word |
| rewind | input | 1 | Send the read position back to the first word for replay |
| empty | output | 1 | Fill count is zero |
| full | output | 1 | Fill count equals DEPTH |
| half_full | output | 1 | Fill count above DEPTH/2 |

## Verification
The bench targets the fill-state edges: pops on an empty buffer, which a design without the guard would turn into a phantom word and a count that underflows to a large value, and a push on a full buffer, where a missing guard would overwrite the oldest unread word so that the drain count and data order break. It checks `half_full` at exactly half and one above, catching an off-by-one in the threshold compare, and crosses the address wrap with paired push/pop cycles, where a wrong count update on simultaneous requests shows up as a wrong drain length. A rewind with both requests raised is checked by the replay length and first word, which would expose a design that still accepted the push or did not reload the count.

// File: rtl/fifo9_pkg.sv
package fifo9_pkg;

    // Word width; bit 8 is an ordinary stored bit (parity or marker)
    localparam int WORD_W = 9;

    typedef logic [WORD_W-1:0] word_t;

    // Address width for a given depth
    function automatic int addr_bits(input int depth);
        return $clog2(depth);
    endfunction

endpackage

// File: rtl/fifo9_ram.sv
// Dual-port word store: one write port, one read port with a registered
// output that only loads on an accepted pop.
module fifo9_ram
    import fifo9_pkg::*;
#(
    parameter int DEPTH  = 256,
    localparam int ADDR_W = addr_bits(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_go,
    input  logic [ADDR_W-1:0] wr_addr,
    input  word_t             wr_word,
    input  logic              rd_go,
    input  logic [ADDR_W-1:0] rd_addr,
    output word_t             rd_word
);

    word_t mem [DEPTH];

    word_t rd_word_d;
    word_t rd_word_q;

    // Array write port
    always_ff @(posedge clk) begin
        if (wr_go) begin
            mem[wr_addr] <= wr_word;
        end
    end

    // Next output word: load on pop, hold otherwise
    always_comb begin
        rd_word_d = rd_word_q;
        if (rd_go) begin
            rd_word_d = mem[rd_addr];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_word_q <= '0;
        end else begin
            rd_word_q <= rd_word_d;
        end
    end

    assign rd_word = rd_word_q;

endmodule

// File: rtl/fifo9_flags.sv
// Fill-state decode from the occupancy count.
module fifo9_flags #(
    parameter int DEPTH  = 256,
    localparam int CNT_W = $clog2(DEPTH) + 1
) (
    input  logic [CNT_W-1:0] level,
    output logic             empty,
    output logic             full,
    output logic             half_full
);

    localparam logic [CNT_W-1:0] FULL_LVL = CNT_W'(DEPTH);
    localparam logic [CNT_W-1:0] HALF_LVL = CNT_W'(DEPTH / 2);

    always_comb begin
        empty     = (level == '0);
        full      = (level == FULL_LVL);
        half_full = (level > HALF_LVL);
    end

endmodule

// File: rtl/fifo9_ctrl.sv
// Pointer and occupancy sequencing, including the rewind reload.
module fifo9_ctrl
    import fifo9_pkg::*;
#(
    parameter int DEPTH   = 256,
    localparam int ADDR_W = addr_bits(DEPTH),
    localparam int CNT_W  = ADDR_W + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic              rewind,
    input  logic              empty,
    input  logic              full,
    output logic              wr_go,
    output logic              rd_go,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [ADDR_W-1:0] rd_addr,
    output logic [CNT_W-1:0]  level
);

    localparam logic [CNT_W-1:0]  FULL_LVL = CNT_W'(DEPTH);
    localparam logic [CNT_W-1:0]  ONE_C    = CNT_W'(1);
    localparam logic [ADDR_W-1:0] ONE_A    = ADDR_W'(1);

    // The write pointer is one bit wider than the address so that a
    // buffer filled from reset reloads a count of DEPTH on rewind.
    typedef struct packed {
        logic [CNT_W-1:0]  wr_ptr;
        logic [ADDR_W-1:0] rd_ptr;
        logic [CNT_W-1:0]  level;
    } ctrl_t;

    ctrl_t st_d;
    ctrl_t st_q;

    always_comb begin
        st_d  = st_q;
        wr_go = wr_en && !full  && !rewind;
        rd_go = rd_en && !empty && !rewind;

        if (rewind) begin
            st_d.rd_ptr = '0;
            st_d.level  = (st_q.wr_ptr > FULL_LVL) ? FULL_LVL : st_q.wr_ptr;
        end else begin
            if (wr_go) begin
                st_d.wr_ptr = st_q.wr_ptr + ONE_C;
            end
            if (rd_go) begin
                st_d.rd_ptr = st_q.rd_ptr + ONE_A;
            end
            unique case ({wr_go, rd_go})
                2'b10:   st_d.level = st_q.level + ONE_C;
                2'b01:   st_d.level = st_q.level - ONE_C;
                default: st_d.level = st_q.level;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign wr_addr = st_q.wr_ptr[ADDR_W-1:0];
    assign rd_addr = st_q.rd_ptr;
    assign level   = st_q.level;

endmodule

// File: rtl/fifo9_replay.sv
// Nine-bit FIFO with rewind-and-replay and half-full status.
module fifo9_replay
    import fifo9_pkg::*;
#(
    parameter int DEPTH = 256
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [WORD_W-1:0] rd_data,
    input  logic              rewind,
    output logic              empty,
    output logic              full,
    output logic              half_full
);

    localparam int ADDR_W = addr_bits(DEPTH);
    localparam int CNT_W  = ADDR_W + 1;

    logic              wr_go;
    logic              rd_go;
    logic [ADDR_W-1:0] wr_addr;
    logic [ADDR_W-1:0] rd_addr;
    logic [CNT_W-1:0]  level;

    fifo9_flags #(.DEPTH(DEPTH)) u_flags (
        .level     (level),
        .empty     (empty),
        .full      (full),
        .half_full (half_full)
    );

    fifo9_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .rd_en   (rd_en),
        .rewind  (rewind),
        .empty   (empty),
        .full    (full),
        .wr_go   (wr_go),
        .rd_go   (rd_go),
        .wr_addr (wr_addr),
        .rd_addr (rd_addr),
        .level   (level)
    );

    fifo9_ram #(.DEPTH(DEPTH)) u_ram (
        .clk     (clk),
        .rst     (rst),
        .wr_go   (wr_go),
        .wr_addr (wr_addr),
        .wr_word (wr_data),
        .rd_go   (rd_go),
        .rd_addr (rd_addr),
        .rd_word (rd_data)
    );

endmodule

// File: rtl/fifo9_replay_chk.sv
module fifo9_replay_chk #(
    parameter int DEPTH  = 256,
    localparam int CNT_W = $clog2(DEPTH) + 1
) (
    input logic             clk,
    input logic             rst,
    input logic             wr_en,
    input logic             rd_en,
    input logic             rt,
    input logic             empty,
    input logic             full,
    input logic             half,
    input logic [8:0]       dout,
    input logic [CNT_W-1:0] level
);

    // R8
    reset_clears_chk: assert property (@(posedge clk)
        rst |=> (empty && !full && !half && dout == 9'h000));

    // R4
    no_underflow_chk: assert property (@(posedge clk) disable iff (rst)
        (empty && rd_en && !wr_en && !rt) |=> (empty && $stable(dout)));

    // R5
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        (full && wr_en && !rd_en && !rt) |=> (full && $stable(level)));

    // R6
    full_implies_half_chk: assert property (@(posedge clk) disable iff (rst)
        full |-> half);

    // R3
    paired_ops_level_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && rd_en && !empty && !full && !rt) |=> $stable(level));

    // R9
    dout_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!rd_en || empty || rt) |=> $stable(dout));

    // R7
    rewind_keeps_data_chk: assert property (@(posedge clk) disable iff (rst)
        (rt && !empty) |=> !empty);

endmodule

bind fifo9_replay fifo9_replay_chk #(.DEPTH(DEPTH)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (wr_en),
    .rd_en  (rd_en),
    .rt     (rewind),
    .empty  (empty),
    .full   (full),
    .half   (half_full),
    .dout   (rd_data),
    .level  (level)
);

// File: tb/tb_fifo9_replay.sv
`timescale 1ns/1ps
module tb_fifo9_replay;

    localparam int DEPTH = 256;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic       rewind = 1'b0;
    logic [8:0] wr_data = '0;
    logic [8:0] rd_data;
    logic       empty;
    logic       full;
    logic       half_full;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    // Bench model
    logic [8:0] hist [DEPTH];
    int         wr_idx = 0;
    int         rd_idx = 0;
    int         exp_level = 0;
    logic [8:0] exp_dout = '0;
    logic [8:0] exp_q [$];

    always #4 clk = ~clk;

    fifo9_replay #(.DEPTH(DEPTH)) dut (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .rd_en     (rd_en),
        .rd_data   (rd_data),
        .rewind    (rewind),
        .empty     (empty),
        .full      (full),
        .half_full (half_full)
    );

    task automatic chk(input string tag, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Driver: one cycle of stimulus, model update, scoreboard push
    task automatic step(input bit w, input logic [8:0] d, input bit r, input bit t);
        bit wa;
        bit ra;
        wr_en   = w;
        wr_data = d;
        rd_en   = r;
        rewind  = t;
        wa = w && !t && (exp_level < DEPTH);
        ra = r && !t && (exp_level > 0);
        @(posedge clk);
        if (t) begin
            rd_idx    = 0;
            exp_level = wr_idx;
        end else begin
            if (ra) begin
                exp_dout = hist[rd_idx % DEPTH];
                exp_q.push_back(exp_dout);
                rd_idx++;
            end
            if (wa) begin
                hist[wr_idx % DEPTH] = d;
                wr_idx++;
            end
            exp_level += int'(wa) - int'(ra);
        end
        @(negedge clk);
        wr_en  = 1'b0;
        rd_en  = 1'b0;
        rewind = 1'b0;
        chk("R4 empty flag", empty, int'(exp_level == 0));
        chk("R5 full flag", full, int'(exp_level == DEPTH));
        chk("R6 half flag", half_full, int'(exp_level > DEPTH / 2));
        chk("R9 rd_data hold/update", rd_data, exp_dout);
    endtask

    // Monitor: pop expected words and compare with what the design returns
    always @(negedge clk) begin : monitor
        logic [8:0] e;
        if (exp_q.size() > 0) begin
            e = exp_q.pop_front();
            chk("R2 pop order/data", rd_data, e);
        end
    end

    task automatic do_reset();
        rst = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst       = 1'b0;
        wr_idx    = 0;
        rd_idx    = 0;
        exp_level = 0;
        exp_dout  = '0;
        exp_q.delete();
        chk("R8 empty after reset", empty, 1);
        chk("R8 full after reset", full, 0);
        chk("R8 half after reset", half_full, 0);
        chk("R8 rd_data after reset", rd_data, 0);
    endtask

    task automatic drain(output int n);
        n = 0;
        while (!empty && n < 2 * DEPTH) begin
            step(1'b0, '0, 1'b1, 1'b0);
            n++;
        end
    endtask

    function automatic logic [8:0] pat(input int i);
        case (i)
            0:       return 9'h1FF;
            1:       return 9'h100;
            2:       return 9'h0AA;
            3:       return 9'h155;
            4:       return 9'h001;
            default: return 9'h1C3;
        endcase
    endfunction

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin : main
        int n;
        @(negedge clk);
        do_reset();

        // R4: pops on an empty buffer are refused
        step(1'b0, '0, 1'b1, 1'b0);
        step(1'b0, '0, 1'b1, 1'b0);
        chk("R4 rd_data kept on empty pop", rd_data, 0);

        // R1: nine-bit patterns including bit 8
        for (int i = 0; i < 6; i++) step(1'b1, pat(i), 1'b0, 1'b0);
        step(1'b0, '0, 1'b1, 1'b0);
        chk("R1 bit 8 returned", rd_data[8], 1);
        chk("R1 full word returned", rd_data, 9'h1FF);
        step(1'b0, '0, 1'b1, 1'b0);

        // R3: paired push and pop keep the fill count (4 words)
        for (int i = 0; i < 3; i++) step(1'b1, 9'(9'h0F0 + i), 1'b1, 1'b0);
        drain(n);
        chk("R3 drain length after paired ops", n, 4);
        step(1'b0, '0, 1'b1, 1'b0);

        // R7: rewind with both requests high; push ignored, replay from first
        step(1'b1, 9'h033, 1'b1, 1'b1);
        chk("R7 not empty after rewind", empty, 0);
        step(1'b0, '0, 1'b1, 1'b0);
        chk("R7 first replayed word", rd_data, 9'h1FF);
        drain(n);
        chk("R7 replay length", n + 1, 9);

        // R8: reset in mid-stream
        for (int i = 0; i < 3; i++) step(1'b1, 9'(9'h010 + i), 1'b0, 1'b0);
        do_reset();
        step(1'b0, '0, 1'b1, 1'b0);
        chk("R8 nothing left after reset", empty, 1);

        // R6 / R5: fill to DEPTH
        for (int i = 0; i < DEPTH; i++) begin
            step(1'b1, 9'(i * 7 + 3), 1'b0, 1'b0);
            if (i == DEPTH / 2 - 1) chk("R6 half_full low at exactly half", half_full, 0);
            if (i == DEPTH / 2)     chk("R6 half_full high above half", half_full, 1);
        end
        chk("R5 full after DEPTH pushes", full, 1);
        step(1'b1, 9'h1EE, 1'b0, 1'b0);
        chk("R5 still full after refused push", full, 1);
        step(1'b1, 9'h1EE, 1'b1, 1'b0);
        chk("R5 pop accepted while full", full, 0);
        drain(n);
        chk("R5 drain length excludes refused words", n, DEPTH - 1);

        // R2: address wrap with paired traffic
        step(1'b1, 9'h0C0, 1'b0, 1'b0);
        for (int i = 0; i < 20; i++) step(1'b1, 9'(300 + i), 1'b1, 1'b0);
        drain(n);
        chk("R2 drain length across wrap", n, 1);

        @(negedge clk);
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule